// File: doc/BRIEF.md
# Sparse Selectable-Tap Transversal Equalizer

This block is a transversal FIR equalizer for a sampled read signal. Incoming 8-bit samples enter a twenty-point delay line built from nineteen delay sections. The center point carries a fixed weight of +64. A small bank of multipliers serves the rest of the line. Each multiplier has its own signed coefficient and its own position. The position picks the delay-line point that the multiplier reads. The weighted sum is scaled back by 64, rounded and clipped to a signed 8-bit output sample.

Taps are configured through a simple write port. One write loads a tap's coefficient and position together. A position outside the line turns that tap off. A mode input picks the rate-reduction factor. At factor 1 only the lower half of the multiplier bank is in use. At factor 2 every multiplier is in use, and the caller strobes samples at half the clock rate. All state advances only on clocks where the sample strobe is high.

Top module: `sparse_tap_eq`

## Requirements
- R1: While `rst` is high, the following clock edge sets `dout` to 0, clears every tap coefficient to 0 and sets every tap position to 31 (tap off). After reset and before any write, the output is therefore the center term alone.
- R2: The delay line has positions 0 to 19. On a strobed edge, position 0 takes `din` and position k takes the old value of position k-1. The output register loads at that same edge from the delay-line and tap values held just before it, so a sample reaches `dout` one strobe after it enters the line plus as many strobes as its position.
- R3: Position 10 always adds 64 times its sample to the sum, whatever the tap settings. With every tap off, `dout` equals `din` delayed by 11 strobes.
- R4: A tap coefficient is a 7-bit two's-complement value from -64 to +63. A tap adds coefficient times the sample at its selected position, using the full signed range of both operands.
- R5: On an edge with `cfg_we` high and `cfg_tap` below 10, tap `cfg_tap` loads `cfg_coef` and `cfg_pos`. The new setting first affects the output computed at the next strobed edge. A write with `cfg_tap` of 10 to 15 changes no tap.
- R6: A tap whose 5-bit position is 20 to 31 adds nothing to the sum.
- R7: With `rate_half` low (factor 1), only taps 0 to 4 add to the sum, and taps 5 to 9 are ignored. With `rate_half` high (factor 2), taps 0 to 9 all add to the sum.
- R8: On an edge with `smp_en` low, neither the delay line nor `dout` changes.
- R9: The output is floor((S + 32) / 64), where S is the full-precision sum. Values above 127 clip to 127, and values below -128 clip to -128.
- R10: Taps that select the same position, including position 10, each add their own product to the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample strobe; advances the line and the output |
| rate_half | input | 1 | 0: factor 1, five taps; 1: factor 2, ten taps |
| din | input | 8 | Input sample, two's complement |
| cfg_we | input | 1 | Tap write enable |
| cfg_tap | input | 4 | Tap index to write |
| cfg_pos | input | 5 | Tap position; 20 to 31 turns the tap off |
| cfg_coef | input | 7 | Tap coefficient, two's complement |
| dout | output | 8 | Equalized output sample, two's complement |

## Verification
The hardest cases to reach are those where several paths land on one sum. Two taps on the same point, a tap stacked on the fixed center, and upper-bank taps that the mode must mask all fall in this group. A single stream of random samples hides which term is wrong. The stimulus therefore programs these overlaps on purpose and drives lone impulses, so that each product appears alone at a known delay. It then drives full-scale constant inputs with extreme coefficients to push the sum past both clip limits. It also runs factor-2 sequences with a gapped strobe, to show that the line and the output stand still between samples.

// File: rtl/eq_pkg.sv
package eq_pkg;
    localparam int SMP_W      = 8;
    localparam int COEF_W     = 7;
    localparam int POS_W      = 5;
    localparam int IDX_W      = 4;
    localparam int NPOS       = 20;
    localparam int CTR_POS    = 10;
    localparam int CTR_COEF   = 64;
    localparam int FRAC_SH    = 6;
    localparam int MAX_PROG   = 10;
    localparam int PROD_W     = SMP_W + COEF_W;
    localparam int ACC_W      = PROD_W + $clog2(MAX_PROG + 2);
    localparam int ROUND_HALF = 1 << (FRAC_SH - 1);
    localparam int SMP_MAX    = (1 << (SMP_W - 1)) - 1;
    localparam int SMP_MIN    = -(1 << (SMP_W - 1));

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic        [POS_W-1:0]  pos_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        pos_t  pos;
        coef_t coef;
    } tap_cfg_t;

    function automatic smp_t round_sat(input acc_t a);
        acc_t r;
        r = (a + acc_t'(ROUND_HALF)) >>> FRAC_SH;
        if (r > acc_t'(SMP_MAX))
            return smp_t'(SMP_MAX);
        else if (r < acc_t'(SMP_MIN))
            return smp_t'(SMP_MIN);
        return smp_t'(r);
    endfunction
endpackage

// File: rtl/eq_coef_bank.sv
module eq_coef_bank
    import eq_pkg::*;
#(
    parameter int NPROG = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  tap_cfg_t         wdata,
    output tap_cfg_t         cfg [NPROG]
);
    for (genvar i = 0; i < NPROG; i++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[i].pos  <= '1;
                cfg[i].coef <= '0;
            end else if (we && idx == IDX_W'(i)) begin
                cfg[i] <= wdata;
            end
        end
    end
endmodule

// File: rtl/eq_delay_line.sv
module eq_delay_line
    import eq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  smp_t din,
    output smp_t line [NPOS]
);
    always_ff @(posedge clk) begin
        if (rst)
            line[0] <= '0;
        else if (en)
            line[0] <= din;
    end

    for (genvar k = 1; k < NPOS; k++) begin : g_sec
        always_ff @(posedge clk) begin
            if (rst)
                line[k] <= '0;
            else if (en)
                line[k] <= line[k-1];
        end
    end
endmodule

// File: rtl/eq_tap_mac.sv
module eq_tap_mac
    import eq_pkg::*;
#(
    parameter int NPROG = 10,
    parameter int NLOW  = 5
) (
    input  smp_t     line [NPOS],
    input  tap_cfg_t cfg  [NPROG],
    input  logic     rate_half,
    output acc_t     sum
);
    acc_t prod [NPROG];

    for (genvar i = 0; i < NPROG; i++) begin : g_mul
        smp_t sel;
        logic live;

        always_comb begin
            sel = '0;
            for (int k = 0; k < NPOS; k++)
                if (cfg[i].pos == POS_W'(k))
                    sel = line[k];
        end

        if (i < NLOW) begin : g_always
            assign live = 1'b1;
        end else begin : g_upper
            assign live = rate_half;
        end

        assign prod[i] = live ? acc_t'(sel) * acc_t'($signed(cfg[i].coef)) : '0;
    end

    always_comb begin
        sum = acc_t'(line[CTR_POS]) * acc_t'(CTR_COEF);
        for (int i = 0; i < NPROG; i++)
            sum = sum + prod[i];
    end
endmodule

// File: rtl/sparse_tap_eq.sv
module sparse_tap_eq
    import eq_pkg::*;
#(
    parameter int NPROG = 10,
    parameter int NLOW  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_en,
    input  logic              rate_half,
    input  logic [SMP_W-1:0]  din,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_tap,
    input  logic [POS_W-1:0]  cfg_pos,
    input  logic [COEF_W-1:0] cfg_coef,
    output logic [SMP_W-1:0]  dout
);
    smp_t     line [NPOS];
    tap_cfg_t cfg  [NPROG];
    tap_cfg_t wdata;
    acc_t     mac_sum;
    smp_t     out_q;

    assign wdata.pos  = cfg_pos;
    assign wdata.coef = coef_t'(cfg_coef);

    eq_coef_bank #(.NPROG(NPROG)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .idx   (cfg_tap),
        .wdata (wdata),
        .cfg   (cfg)
    );

    eq_delay_line u_line (
        .clk  (clk),
        .rst  (rst),
        .en   (smp_en),
        .din  (smp_t'(din)),
        .line (line)
    );

    eq_tap_mac #(.NPROG(NPROG), .NLOW(NLOW)) u_mac (
        .line      (line),
        .cfg       (cfg),
        .rate_half (rate_half),
        .sum       (mac_sum)
    );

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else if (smp_en)
            out_q <= round_sat(mac_sum);
    end

    assign dout = out_q;
endmodule

// File: rtl/eq_checker.sv
module eq_checker
    import eq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              smp_en,
    input logic              cfg_we,
    input logic [IDX_W-1:0]  cfg_tap,
    input logic [POS_W-1:0]  cfg_pos,
    input logic [COEF_W-1:0] cfg_coef,
    input tap_cfg_t          cfg0,
    input smp_t              line0,
    input smp_t              line1,
    input acc_t              acc,
    input logic [SMP_W-1:0]  dout
);
    localparam int SAT_HI = SMP_MAX * CTR_COEF + ROUND_HALF;
    localparam int SAT_LO = SMP_MIN * CTR_COEF - ROUND_HALF;

    logic rst_q;
    always_ff @(posedge clk) begin
        if (rst_q === 1'b1)
            AST_RESET_ZERO: assert (dout == '0); // R1
        rst_q <= rst;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> $stable(dout)); // R8

    AST_LINE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        smp_en |=> line1 == $past(line0)); // R2

    AST_CLIP_HIGH: assert property (@(posedge clk) disable iff (rst)
        (smp_en && acc >= acc_t'(SAT_HI)) |=> dout == SMP_W'(SMP_MAX)); // R9

    AST_CLIP_LOW: assert property (@(posedge clk) disable iff (rst)
        (smp_en && acc < acc_t'(SAT_LO)) |=> $signed(dout) == smp_t'(SMP_MIN)); // R9

    AST_TAP_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_tap == '0) |=> (cfg0.pos == $past(cfg_pos) && cfg0.coef == $past(cfg_coef))); // R5
endmodule

bind sparse_tap_eq eq_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_en   (smp_en),
    .cfg_we   (cfg_we),
    .cfg_tap  (cfg_tap),
    .cfg_pos  (cfg_pos),
    .cfg_coef (cfg_coef),
    .cfg0     (cfg[0]),
    .line0    (line[0]),
    .line1    (line[1]),
    .acc      (mac_sum),
    .dout     (dout)
);

// File: tb/sparse_tap_eq_test.sv
module sparse_tap_eq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_en = 1'b0;
    logic       rate_half = 1'b0;
    logic [7:0] din = '0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_tap = '0;
    logic [4:0] cfg_pos = '0;
    logic [6:0] cfg_coef = '0;
    logic [7:0] dout;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string req = "R1";

    int m_line [20];
    int m_coef [10];
    int m_pos  [10];
    int m_exp  = 0;

    always #4 clk = ~clk;

    sparse_tap_eq uut (
        .clk(clk), .rst(rst), .smp_en(smp_en), .rate_half(rate_half),
        .din(din), .cfg_we(cfg_we), .cfg_tap(cfg_tap), .cfg_pos(cfg_pos),
        .cfg_coef(cfg_coef), .dout(dout)
    );

    // Behavioural reference, updated at every rising edge from the driven inputs
    always @(posedge clk) begin
        int s;
        if (rst) begin
            m_exp = 0;
            foreach (m_line[k]) m_line[k] = 0;
            foreach (m_coef[i]) begin m_coef[i] = 0; m_pos[i] = 31; end
        end else begin
            if (smp_en) begin
                s = 64 * m_line[10];
                for (int i = 0; i < 10; i++)
                    if (m_pos[i] < 20 && (rate_half || i < 5))
                        s += m_coef[i] * m_line[m_pos[i]];
                s = (s + 32) >>> 6;
                if (s > 127) s = 127;
                if (s < -128) s = -128;
                m_exp = s;
                for (int k = 19; k > 0; k--) m_line[k] = m_line[k-1];
                m_line[0] = $signed(din);
            end
            if (cfg_we && cfg_tap < 10) begin
                m_coef[cfg_tap] = $signed(cfg_coef);
                m_pos[cfg_tap]  = cfg_pos;
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        n_run++;
        if (dout !== 8'(m_exp)) begin
            n_fail++;
            $display("FAIL %s: dout=%0d expected=%0d", req, $signed(dout), m_exp);
        end
    endtask

    task automatic put(input int tap, input int pos, input int coef);
        cfg_we = 1'b1; cfg_tap = 4'(tap); cfg_pos = 5'(pos); cfg_coef = 7'(coef);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic clear_taps();
        for (int i = 0; i < 10; i++) put(i, 31, 0);
    endtask

    task automatic run(input int n, input int val, input bit rnd);
        for (int j = 0; j < n; j++) begin
            din = rnd ? 8'($urandom_range(0, 255)) : 8'(val);
            tick();
        end
    endtask

    task automatic impulse(input int amp);
        din = 8'(amp); tick();
        run(24, 0, 1'b0);
    endtask

    initial begin
        req = "R1"; run(3, 0, 1'b0);
        rst = 1'b0; smp_en = 1'b1;
        req = "R1"; run(4, 5, 1'b0);

        req = "R3"; impulse(90); run(40, 0, 1'b1);
        req = "R2"; put(0, 0, 32); put(1, 19, -20); put(2, 4, 17); impulse(64); impulse(-100);
        req = "R4"; put(3, 7, -64); put(4, 12, 63); impulse(-128); impulse(127);
        req = "R4"; run(30, 0, 1'b1);

        req = "R9"; clear_taps();
        for (int i = 0; i < 5; i++) put(i, 2 * i + 1, 63);
        run(30, 127, 1'b0); run(30, -128, 1'b0);
        for (int i = 0; i < 5; i++) put(i, 2 * i + 1, -64);
        run(30, 127, 1'b0); run(30, -128, 1'b0);
        req = "R9"; clear_taps(); put(0, 3, 1); run(40, 0, 1'b1);

        req = "R10"; clear_taps(); put(0, 6, 20); put(1, 6, 30); put(2, 10, -50);
        impulse(100); impulse(-77);

        req = "R6"; put(0, 20, 63); put(1, 31, -64); put(3, 25, 50); impulse(120);

        req = "R7"; clear_taps(); put(5, 2, 60); put(9, 15, -40); put(7, 10, 63);
        impulse(100); run(20, 0, 1'b1);
        req = "R7"; rate_half = 1'b1; put(1, 4, 25);
        for (int j = 0; j < 60; j++) begin
            smp_en = j[0];
            din = (j == 4) ? 8'd100 : 8'($urandom_range(0, 255));
            tick();
        end

        req = "R8"; smp_en = 1'b0; run(10, 77, 1'b1);
        for (int j = 0; j < 50; j++) begin
            smp_en = ($urandom_range(0, 2) == 0);
            din = 8'($urandom_range(0, 255));
            tick();
        end
        smp_en = 1'b1;

        req = "R5"; put(12, 5, 40); put(15, 0, -30); put(10, 10, 63); impulse(100);
        req = "R5"; put(8, 1, 33); impulse(50);

        req = "R1"; rst = 1'b1; run(2, 9, 1'b0); rst = 1'b0; impulse(70);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=not finished expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule